// File: doc/BRIEF.md
# Pop-Free Processing and Power Sequencer

This block sits between a host's control settings and a soft-stepping volume stage in an audio output path. Whenever the host asks to switch the de-emphasis filter or the effects processing on or off, or asks to power the converter up or down, the sequencer keeps the change away from the audio until it is silent. It forces the volume stage to ramp to mute, waits for the stage to report that its ramp has settled, commits the new processing enables, holds them for one sample period, and then releases the mute so the stage ramps back to the host's level. At power-down it ramps to mute before removing the converter's power enable, and then raises a flag that tells the host the clock may be stopped.

The host's own mute and gain targets are never overwritten. Gain passes through untouched, and the host mute is restored as soon as the sequencer stops forcing mute. Processing toggles that arrive while a change is under way are merged and committed together. A power-down request pre-empts any change sequence, and the pending unmute is then dropped. The volume arithmetic and the filters are outside the block. It only delivers the committed enables and the power enable.

Top module: `popfree_seq`

## Requirements
- R1: While reset is held low at a clock edge (synchronous, active low), and after its release, `pwr_en` is 0, `pd_done` is 1, `vol_mute` is 1 and `proc_en` is 0 (with `proc_req` at 0).
- R2: While powered down, `proc_en` takes the value of `proc_req` one clock later, and `vol_mute` stays at 1 whatever `host_mute` is.
- R3: When `power_req` is 1 at an edge while powered down, `pwr_en` becomes 1 and `pd_done` becomes 0 after that edge, and `vol_mute` follows `host_mute` so the stage ramps up from mute.
- R4: `vol_settled` is ignored in the first clock cycle after any state change, so a stale settled flag cannot complete a ramp.
- R5: When powered up and idle, a `proc_req` value that differs from `proc_en` drives `vol_mute` to 1 on the next clock, while `proc_en` keeps its old value.
- R6: `proc_en` changes while powered up only at an edge where `vol_mute` is 1 and `vol_settled` is accepted, and it then loads the current `proc_req`, so several toggles made during the mute ramp are committed together as one change.
- R7: After the commit, `vol_mute` stays at 1 until the first `sample_tick` that comes after the commit's own cycle. From the next clock it follows `host_mute` again.
- R8: When the unmute ramp reports settled, the sequencer returns to idle, and a later `proc_req` change starts a new mute sequence.
- R9: If `power_req` is 0 at an edge during ramp-up, idle, or any phase of a change sequence, the sequencer goes to the power-down ramp at once, with `vol_mute` at 1, and the unmute is discarded.
- R10: During the power-down ramp `pwr_en` stays at 1 until `vol_settled` is accepted. After that edge `pwr_en` is 0 and `pd_done` is 1.
- R11: `vol_gain` always equals `host_gain`, and when forcing ends `vol_mute` returns to the host's current `host_mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse per audio sample period |
| power_req | input | 1 | Host asks for the converter to be powered |
| proc_req | input | PROC_W | Host processing enables requested (bit 0 de-emphasis, bit 1 effects) |
| host_mute | input | 1 | Host mute target |
| host_gain | input | GAIN_W | Host attenuation target, 0.5 dB per step |
| vol_settled | input | 1 | Volume stage reports its actual level equals its target |
| vol_mute | output | 1 | Mute command to the volume stage |
| vol_gain | output | GAIN_W | Gain target to the volume stage |
| proc_en | output | PROC_W | Committed processing enables for the datapath |
| pwr_en | output | 1 | Converter power enable |
| pd_done | output | 1 | Power-down complete; clock may be stopped |

## Verification
The bench leaves `vol_settled` stuck high across a state change and checks that nothing commits in the first cycle. A design without the guard would load `proc_req` before the mute ramp had even started. It changes `proc_req` twice inside one mute ramp and checks that only the final value shows up on `proc_en`. A design that committed on every toggle would let a half-applied setting reach live audio. It pulses `sample_tick` in the cycle that the commit lands and checks that the mute is still held. A design that counted that pulse would unmute almost at once. Finally, it drops `power_req` in the middle of the commit phase with ticks still arriving. It checks that the mute is never released and that `pwr_en` stays high until the settled flag is seen. A design that finished the unmute, or cut power early, would produce an audible click.

// File: rtl/popfree_seq_pkg.sv
// Shared types for the pop-free sequencer.
// Assumes: single clock domain; state encoding is private to the block.
package popfree_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF      = 3'd0,
        SQ_RAMP_UP  = 3'd1,
        SQ_ACTIVE   = 3'd2,
        SQ_MUTE_CHG = 3'd3,
        SQ_APPLY    = 3'd4,
        SQ_UNMUTE   = 3'd5,
        SQ_MUTE_OFF = 3'd6
    } seq_state_t;

    // States in which the sequencer overrides the host mute.
    function automatic logic seq_forces_mute(seq_state_t s);
        return (s == SQ_OFF) || (s == SQ_MUTE_CHG) ||
               (s == SQ_APPLY) || (s == SQ_MUTE_OFF);
    endfunction

endpackage

// File: rtl/popfree_seq_fsm.sv
// Sequencing state machine.
// Does: walks the power-up, mute-change-unmute and power-down sequences,
//       and emits a one-cycle commit strobe when the mute ramp has settled.
// Assumes: vol_settled reflects the volume command from the cycle before,
//          so settled is trusted only after one cycle in a state.
module popfree_seq_fsm
    import popfree_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick_i,
    input  logic       power_req_i,
    input  logic       vol_settled_i,
    input  logic       change_pending_i,
    output seq_state_t state_o,
    output logic       commit_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       fresh_q;
    logic       settled_ok;

    // Settled flag is only believed once the state has aged one cycle.
    assign settled_ok = vol_settled_i && !fresh_q;

    // Next-state selection; a power drop pre-empts every powered state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_OFF: begin
                if (power_req_i) state_d = SQ_RAMP_UP;
            end
            SQ_RAMP_UP: begin
                if (!power_req_i)          state_d = SQ_MUTE_OFF;
                else if (change_pending_i) state_d = SQ_MUTE_CHG;
                else if (settled_ok)       state_d = SQ_ACTIVE;
            end
            SQ_ACTIVE: begin
                if (!power_req_i)          state_d = SQ_MUTE_OFF;
                else if (change_pending_i) state_d = SQ_MUTE_CHG;
            end
            SQ_MUTE_CHG: begin
                if (!power_req_i)    state_d = SQ_MUTE_OFF;
                else if (settled_ok) state_d = SQ_APPLY;
            end
            SQ_APPLY: begin
                if (!power_req_i)                   state_d = SQ_MUTE_OFF;
                else if (sample_tick_i && !fresh_q) state_d = SQ_UNMUTE;
            end
            SQ_UNMUTE: begin
                if (!power_req_i)    state_d = SQ_MUTE_OFF;
                else if (settled_ok) state_d = SQ_ACTIVE;
            end
            SQ_MUTE_OFF: begin
                if (settled_ok) state_d = SQ_OFF;
            end
            default: state_d = SQ_OFF;
        endcase
    end

    // State register plus the "entered this state last edge" marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_OFF;
            fresh_q <= 1'b1;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_d != state_q);
        end
    end

    assign state_o  = state_q;
    assign commit_o = (state_q == SQ_MUTE_CHG) && (state_d == SQ_APPLY);

    // R9
    off_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_req_i && (state_q inside {SQ_RAMP_UP, SQ_ACTIVE, SQ_MUTE_CHG,
                                          SQ_APPLY, SQ_UNMUTE}))
        |=> (state_q == SQ_MUTE_OFF));

endmodule

// File: rtl/popfree_seq_req_track.sv
// Committed processing enables.
// Does: holds the enables seen by the datapath, reloads them from the host
//       request when told to, and flags a request that differs from them.
// Assumes: load is asserted only while the output is silent.
module popfree_seq_req_track #(
    parameter int PROC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PROC_W-1:0] proc_req_i,
    input  logic              load_i,
    output logic [PROC_W-1:0] proc_en_o,
    output logic              pending_o
);

    logic [PROC_W-1:0] en_q;
    logic [PROC_W-1:0] diff;

    // One register per processing function; all reload on the same strobe.
    for (genvar i = 0; i < PROC_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      en_q[i] <= 1'b0;
            else if (load_i) en_q[i] <= proc_req_i[i];
        end
        assign diff[i] = en_q[i] ^ proc_req_i[i];
    end

    assign proc_en_o = en_q;
    assign pending_o = |diff;

endmodule

// File: rtl/popfree_seq_vol_ctl.sv
// Volume-stage command mux.
// Does: forces mute during silent phases, otherwise passes the host mute;
//       the host gain target is passed through unchanged at all times.
// Assumes: the volume stage soft-steps towards whatever it is given.
module popfree_seq_vol_ctl
    import popfree_seq_pkg::*;
#(
    parameter int GAIN_W = 7
) (
    input  seq_state_t        state_i,
    input  logic              host_mute_i,
    input  logic [GAIN_W-1:0] host_gain_i,
    output logic              vol_mute_o,
    output logic [GAIN_W-1:0] vol_gain_o
);

    // Mute override never touches the host's stored targets.
    always_comb begin
        vol_mute_o = seq_forces_mute(state_i) | host_mute_i;
        vol_gain_o = host_gain_i;
    end

endmodule

// File: rtl/popfree_seq.sv
// Pop-free processing and power sequencer, top level.
// Does: defers processing-enable and power changes until the soft-stepping
//       volume stage has ramped to mute, then restores the host volume.
// Assumes: sample_tick is a one-cycle pulse per sample; vol_settled comes
//          from the volume stage and lags its command by at least a cycle.
module popfree_seq
    import popfree_seq_pkg::*;
#(
    parameter int PROC_W = 2,
    parameter int GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              power_req,
    input  logic [PROC_W-1:0] proc_req,
    input  logic              host_mute,
    input  logic [GAIN_W-1:0] host_gain,
    input  logic              vol_settled,
    output logic              vol_mute,
    output logic [GAIN_W-1:0] vol_gain,
    output logic [PROC_W-1:0] proc_en,
    output logic              pwr_en,
    output logic              pd_done
);

    seq_state_t state;
    logic       commit;
    logic       pending;
    logic       load_en;

    // Enables follow the request freely while off; else only on commit.
    assign load_en = (state == SQ_OFF) || commit;

    popfree_seq_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .sample_tick_i    (sample_tick),
        .power_req_i      (power_req),
        .vol_settled_i    (vol_settled),
        .change_pending_i (pending),
        .state_o          (state),
        .commit_o         (commit)
    );

    popfree_seq_req_track #(.PROC_W(PROC_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_req_i (proc_req),
        .load_i     (load_en),
        .proc_en_o  (proc_en),
        .pending_o  (pending)
    );

    popfree_seq_vol_ctl #(.GAIN_W(GAIN_W)) u_vol (
        .state_i     (state),
        .host_mute_i (host_mute),
        .host_gain_i (host_gain),
        .vol_mute_o  (vol_mute),
        .vol_gain_o  (vol_gain)
    );

    // Power status derived from the sequencing state.
    assign pwr_en  = (state != SQ_OFF);
    assign pd_done = (state == SQ_OFF);

    // R6
    commit_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(proc_en) |-> $past(!pwr_en || (vol_mute && vol_settled)));

    // R10
    pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(vol_mute && vol_settled));

    // R7
    apply_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_APPLY) |-> vol_mute);

endmodule

// File: tb/popfree_seq_bench.sv
// Directed bench for popfree_seq: one task per scenario, inputs driven and
// outputs sampled on the falling clock edge.
module popfree_seq_bench;

    localparam int  PROC_W = 2;
    localparam int  GAIN_W = 7;
    localparam time CLK_PERIOD = 4ns;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sample_tick;
    logic              power_req;
    logic [PROC_W-1:0] proc_req;
    logic              host_mute;
    logic [GAIN_W-1:0] host_gain;
    logic              vol_settled;
    logic              vol_mute;
    logic [GAIN_W-1:0] vol_gain;
    logic [PROC_W-1:0] proc_en;
    logic              pwr_en;
    logic              pd_done;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    popfree_seq #(.PROC_W(PROC_W), .GAIN_W(GAIN_W)) u_popfree_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .power_req   (power_req),
        .proc_req    (proc_req),
        .host_mute   (host_mute),
        .host_gain   (host_gain),
        .vol_settled (vol_settled),
        .vol_mute    (vol_mute),
        .vol_gain    (vol_gain),
        .proc_en     (proc_en),
        .pwr_en      (pwr_en),
        .pd_done     (pd_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Walk out of the commit phase: a tick in its first cycle, then a real one.
    task automatic leave_apply();
        sample_tick = 1'b1; step(1);
        sample_tick = 1'b0; step(1);
        sample_tick = 1'b1; step(1);
        sample_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sample_tick = 1'b0; power_req = 1'b0; proc_req = '0;
        host_mute = 1'b0; host_gain = '0; vol_settled = 1'b0;
        step(3);
        chk("R1 pwr_en in reset", pwr_en, 0);
        chk("R1 pd_done in reset", pd_done, 1);
        chk("R1 vol_mute in reset", vol_mute, 1);
        chk("R1 proc_en in reset", proc_en, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 pwr_en after release", pwr_en, 0);
        chk("R1 pd_done after release", pd_done, 1);
    endtask

    task automatic t_off_follow();
        proc_req = 2'b01; step(1);
        chk("R2 proc_en follows while off", proc_en, 2'b01);
        chk("R2 mute forced while off", vol_mute, 1);
        proc_req = 2'b10; step(1);
        chk("R2 proc_en follows while off", proc_en, 2'b10);
        chk("R2 pwr_en stays off", pwr_en, 0);
    endtask

    task automatic t_power_up();
        host_mute = 1'b0; host_gain = 7'd20; vol_settled = 1'b1;
        power_req = 1'b1; step(1);
        chk("R3 pwr_en up", pwr_en, 1);
        chk("R3 pd_done cleared", pd_done, 0);
        chk("R3 mute released to host", vol_mute, 0);
        chk("R11 gain passed", vol_gain, 7'd20);
        step(2);
        chk("R3 enables untouched", proc_en, 2'b10);
    endtask

    task automatic t_change();
        proc_req = 2'b11; step(1);
        chk("R5 mute forced on change", vol_mute, 1);
        chk("R5 enables held", proc_en, 2'b10);
        proc_req = 2'b01; step(1);
        chk("R4 stale settled ignored", proc_en, 2'b10);
        vol_settled = 1'b0; step(1);
        chk("R5 held until settled", proc_en, 2'b10);
        vol_settled = 1'b1; step(1);
        chk("R6 merged commit", proc_en, 2'b01);
        chk("R6 still muted at commit", vol_mute, 1);
        sample_tick = 1'b1; step(1);
        sample_tick = 1'b0;
        chk("R7 first-cycle tick ignored", vol_mute, 1);
        step(1);
        chk("R7 mute held between ticks", vol_mute, 1);
        sample_tick = 1'b1; step(1);
        sample_tick = 1'b0;
        chk("R7 unmute after one sample", vol_mute, 0);
        vol_settled = 1'b0; step(1);
        vol_settled = 1'b1; step(1);
        proc_req = 2'b00; step(1);
        chk("R8 new change re-mutes", vol_mute, 1);
        chk("R8 enables held again", proc_en, 2'b01);
    endtask

    task automatic t_power_priority();
        vol_settled = 1'b0; step(1);
        vol_settled = 1'b1; step(1);
        chk("R6 second commit", proc_en, 2'b00);
        power_req = 1'b0; step(1);
        chk("R9 mute kept on power drop", vol_mute, 1);
        chk("R10 power held during ramp", pwr_en, 1);
        vol_settled = 1'b0; sample_tick = 1'b1; step(1);
        sample_tick = 1'b0;
        chk("R9 unmute discarded", vol_mute, 1);
        chk("R10 power held unsettled", pwr_en, 1);
        sample_tick = 1'b1; step(1);
        sample_tick = 1'b0;
        chk("R9 unmute discarded", vol_mute, 1);
        chk("R10 pd_done not yet", pd_done, 0);
        vol_settled = 1'b1; step(1);
        chk("R10 power removed", pwr_en, 0);
        chk("R10 pd_done raised", pd_done, 1);
    endtask

    task automatic t_host_hold();
        host_mute = 1'b1; host_gain = 7'd55; vol_settled = 1'b1;
        power_req = 1'b1; step(1);
        chk("R11 host mute kept at ramp-up", vol_mute, 1);
        chk("R11 gain passed", vol_gain, 7'd55);
        step(2);
        proc_req = 2'b11; step(1);
        host_gain = 7'd9; step(1);
        chk("R11 gain tracks host during mute", vol_gain, 7'd9);
        vol_settled = 1'b0; step(1);
        vol_settled = 1'b1; step(1);
        chk("R6 commit with host muted", proc_en, 2'b11);
        leave_apply();
        step(1);
        chk("R11 host mute restored", vol_mute, 1);
        host_mute = 1'b0; step(1);
        chk("R11 host unmute honoured", vol_mute, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_off_follow();
        t_power_up();
        t_change();
        t_power_priority();
        t_host_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule